// File: doc/BRIEF.md
# Serial Clock Divisor Search Engine

This block turns a requested serial bit rate into the two divisor settings a synchronous serial port needs: an even prescale factor and an 8-bit rate divider, where the resulting rate is the source clock divided by prescale times (divider + 1). Both the source clock frequency and the request are given as unsigned integers. A single-cycle `start` launches a search; the engine clamps the request into the range the divisors can reach, finds the first setting in search order whose truncated output rate does not exceed the clamped request, and reports it with a one-cycle `done` pulse.

The search order is fixed: prescale is the outer variable, stepping through even values from 2 up to 254; the rate divider is the inner variable, stepping from 0 to 255. The engine does not walk the inner loop. For each prescale value it first decides with one multiply-compare whether any divider fits. Once a prescale value passes, one iterative division yields the smallest fitting divider directly. The same divider unit computes the lower clamp bound at the start of each search.

Top module: `sdiv_search_engine`

## Requirements
- R1: A `start` seen while idle raises `busy` on the following cycle. The search ends with `done` high for exactly one cycle, and `busy` is low in that same cycle.
- R2: A `start` that arrives while `busy` is high has no effect: the result reported at the next `done` is the one for the request accepted earlier.
- R3: `prescale`, `rate_div` and `no_fit` change only when `done` is pulsed. They hold their values while idle and through a following search until its `done`.
- R4: A request above floor(src_hz / 2) is treated as floor(src_hz / 2).
- R5: A request below floor(src_hz / 65024) is treated as floor(src_hz / 65024), where 65024 = 254 x 256 is the largest divisor product.
- R6: The reported `prescale` is even and lies in 2..254, and `rate_div` lies in 0..255. Candidates are ordered by prescale first, ascending, then by divider, ascending.
- R7: The reported pair is the first candidate in that order for which floor(src_hz / (prescale x (rate_div + 1))) is no greater than the clamped request, using truncating division.
- R8: `no_fit` is raised only if no candidate satisfies R7. Because of the clamp in R5, it stays low for every input.
- R9: After reset, `busy`, `done`, `no_fit`, `prescale` and `rate_div` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a search using `src_hz` and `want_hz` |
| src_hz | input | 32 | Source clock frequency |
| want_hz | input | 32 | Requested serial rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: result valid |
| prescale | output | 8 | Even prescale factor found |
| rate_div | output | 8 | Rate divider found (rate = src / (prescale x (rate_div+1))) |
| no_fit | output | 1 | No candidate satisfied the rule |

## Verification
The bench targets several corner cases of the search itself:
- A zero or tiny source clock. A wrong clamp order or a zero divisor here would return a nonzero pair or hang.
- A request of zero against a large clock, which must land on the very last candidate (254, 255). An off-by-one in the lower bound or the outer limit would stop early or flag `no_fit`.
- A request at or above half the clock, which must give (2, 0).
- Requests whose quotient sits exactly on the boundary. Here an exact-multiplication shortcut that ignores truncation would pick a larger divider than the truncated rule allows.
- Random clocks and requests, compared against a literal nested loop. These expose any skipped prescale value or wrong divider.
- A second `start` during a search, which would corrupt the result if it were latched.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MIN_GO,
    ST_MIN_WAIT,
    ST_CLAMP,
    ST_SCAN,
    ST_SCR_GO,
    ST_SCR_WAIT
  } sdiv_state_e;

  localparam int SDIV_PRE_FIRST = 2;
  localparam int SDIV_PRE_STEP  = 2;

endpackage

// File: rtl/sdiv_seq_divider.sv
module sdiv_seq_divider #(
  parameter int NW = 32,
  parameter int DW = 49
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] numer,
  input  logic [DW-1:0] denom,
  output logic          valid,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q;
  logic [NW-1:0] quo_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial;
  logic          take;
  logic [DW-1:0] diff;

  always_comb begin
    trial = {rem_q, quo_q[NW-1]};
    take  = trial >= {1'b0, den_q};
    diff  = trial[DW-1:0] - den_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= numer;
        den_q <= denom;
        cnt_q <= CW'(NW);
      end else if (cnt_q != '0) begin
        rem_q <= take ? diff : trial[DW-1:0];
        quo_q <= {quo_q[NW-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        valid <= (cnt_q == CW'(1));
      end
    end
  end

  assign quot = quo_q;
endmodule

// File: rtl/sdiv_rate_clamp.sv
module sdiv_rate_clamp #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] req,
  input  logic [W-1:0] lo,
  output logic [W-1:0] clamped
);
  logic [W-1:0] hi;
  logic [W-1:0] capped;

  always_comb begin
    hi      = src >> 1;
    capped  = (req > hi) ? hi : req;
    clamped = (capped < lo) ? lo : capped;
  end
endmodule

// File: rtl/sdiv_search_engine.sv
module sdiv_search_engine
  import sdiv_pkg::*;
#(
  parameter int CLK_W   = 32,
  parameter int PRE_MAX = 254,
  parameter int SCR_MAX = 255
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [CLK_W-1:0]                 src_hz,
  input  logic [CLK_W-1:0]                 want_hz,
  output logic                             busy,
  output logic                             done,
  output logic [$clog2(PRE_MAX+1)-1:0]     prescale,
  output logic [$clog2(SCR_MAX+1)-1:0]     rate_div,
  output logic                             no_fit
);
  localparam int PRE_W   = $clog2(PRE_MAX + 1);
  localparam int SCR_W   = $clog2(SCR_MAX + 1);
  localparam int MW      = CLK_W + PRE_W + SCR_W + 1;
  localparam int MIN_DEN = PRE_MAX * (SCR_MAX + 1);

  // divisor product for one prescale value: (rate + 1) * prescale
  function automatic logic [MW-1:0] pre_span(input logic [CLK_W:0] r1,
                                             input logic [PRE_W-1:0] p);
    return MW'(r1) * MW'(p);
  endfunction

  // some divider fits at this prescale iff src < span * (SCR_MAX + 1)
  function automatic logic any_fit(input logic [CLK_W-1:0] c,
                                   input logic [MW-1:0] span);
    return MW'(c) < span * MW'(SCR_MAX + 1);
  endfunction

  sdiv_state_e      state_q;
  logic [CLK_W-1:0] clk_q;
  logic [CLK_W-1:0] req_q;
  logic [CLK_W-1:0] floor_q;
  logic [CLK_W-1:0] rate_q;
  logic [PRE_W-1:0] pre_q;

  logic [CLK_W:0]   r1;
  logic [MW-1:0]    span;
  logic             scan_fit;
  logic             scan_exhausted;
  logic             div_go;
  logic [MW-1:0]    div_den;
  logic             div_valid;
  logic [CLK_W-1:0] div_q;
  logic [CLK_W-1:0] clamp_out;

  always_comb begin
    r1             = {1'b0, rate_q} + 1'b1;
    span           = pre_span(r1, pre_q);
    scan_fit       = any_fit(clk_q, span);
    scan_exhausted = (pre_q == PRE_W'(PRE_MAX));
    div_go         = (state_q == ST_MIN_GO) || (state_q == ST_SCR_GO);
    div_den        = (state_q == ST_MIN_GO) ? MW'(MIN_DEN) : span;
  end

  sdiv_seq_divider #(.NW(CLK_W), .DW(MW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .numer (clk_q),
    .denom (div_den),
    .valid (div_valid),
    .quot  (div_q)
  );

  sdiv_rate_clamp #(.W(CLK_W)) u_clamp (
    .src     (clk_q),
    .req     (req_q),
    .lo      (floor_q),
    .clamped (clamp_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      clk_q    <= '0;
      req_q    <= '0;
      floor_q  <= '0;
      rate_q   <= '0;
      pre_q    <= '0;
      done     <= 1'b0;
      prescale <= '0;
      rate_div <= '0;
      no_fit   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            clk_q   <= src_hz;
            req_q   <= want_hz;
            state_q <= ST_MIN_GO;
          end
        end
        ST_MIN_GO:   state_q <= ST_MIN_WAIT;
        ST_MIN_WAIT: begin
          if (div_valid) begin
            floor_q <= div_q;
            state_q <= ST_CLAMP;
          end
        end
        ST_CLAMP: begin
          rate_q  <= clamp_out;
          pre_q   <= PRE_W'(SDIV_PRE_FIRST);
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (scan_fit) begin
            state_q <= ST_SCR_GO;
          end else if (scan_exhausted) begin
            prescale <= '0;
            rate_div <= '0;
            no_fit   <= 1'b1;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            pre_q <= pre_q + PRE_W'(SDIV_PRE_STEP);
          end
        end
        ST_SCR_GO:   state_q <= ST_SCR_WAIT;
        ST_SCR_WAIT: begin
          if (div_valid) begin
            prescale <= pre_q;
            rate_div <= div_q[SCR_W-1:0];
            no_fit   <= 1'b0;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sdiv_search_checker.sv
module sdiv_search_checker #(
  parameter int CLK_W   = 32,
  parameter int PRE_W   = 8,
  parameter int SCR_W   = 8,
  parameter int PRE_MAX = 254
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             no_fit,
  input logic [PRE_W-1:0] prescale,
  input logic [SCR_W-1:0] rate_div,
  input logic [CLK_W-1:0] clk_q,
  input logic [CLK_W-1:0] req_q,
  input logic [CLK_W-1:0] rate_q
);
  localparam int MW = CLK_W + PRE_W + SCR_W + 2;

  logic [MW-1:0] prod_here;
  logic [MW-1:0] prod_prev;

  always_comb begin
    prod_here = (MW'(rate_q) + MW'(1)) * MW'(prescale) * (MW'(rate_div) + MW'(1));
    prod_prev = (MW'(rate_q) + MW'(1)) * MW'(prescale) * MW'(rate_div);
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_request_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(clk_q) && $stable(req_q));
  p_result_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(prescale) && $stable(rate_div) && $stable(no_fit));
  p_clamp_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rate_q <= (clk_q >> 1));
  p_prescale_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !no_fit |-> !prescale[0] && prescale >= PRE_W'(2) && prescale <= PRE_W'(PRE_MAX));
  p_pair_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !no_fit |-> MW'(clk_q) < prod_here);
  p_pair_minimal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !no_fit && rate_div != '0 |-> MW'(clk_q) >= prod_prev);
  p_no_fit_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !no_fit);
endmodule

bind sdiv_search_engine sdiv_search_checker #(
  .CLK_W   (CLK_W),
  .PRE_W   (PRE_W),
  .SCR_W   (SCR_W),
  .PRE_MAX (PRE_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .no_fit   (no_fit),
  .prescale (prescale),
  .rate_div (rate_div),
  .clk_q    (clk_q),
  .req_q    (req_q),
  .rate_q   (rate_q)
);

// File: tb/test_sdiv_search_engine.sv
module test_sdiv_search_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_hz = '0;
  logic [31:0] want_hz = '0;
  logic        busy, done, no_fit;
  logic [7:0]  prescale, rate_div;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdiv_search_engine i_sdiv_search_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .src_hz(src_hz), .want_hz(want_hz),
    .busy(busy), .done(done), .prescale(prescale), .rate_div(rate_div), .no_fit(no_fit)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // literal nested search with truncating division
  function automatic void ref_search(input longint unsigned c, input longint unsigned r,
                                     output int p, output int s, output bit e);
    longint unsigned lo, hi, rr;
    lo = c / 65024;
    hi = c / 2;
    rr = r;
    if (rr > hi) rr = hi;
    if (rr < lo) rr = lo;
    e = 1; p = 0; s = 0;
    for (int pp = 2; pp <= 254; pp += 2) begin
      for (int ss = 0; ss <= 255; ss++) begin
        if (c / longint'(pp * (ss + 1)) <= rr) begin
          p = pp; s = ss; e = 0;
          break;
        end
      end
      if (!e) break;
    end
  endfunction

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) check("watchdog R1", 0, 1);
  endtask

  task automatic run(input logic [31:0] c, input logic [31:0] r, input string tag);
    int p, s; bit e, ok;
    ref_search(c, r, p, s, e);
    @(negedge clk);
    src_hz = c; want_hz = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R1 busy after start ", tag}, busy, 1);
    wait_done(ok);
    if (ok) begin
      check({"R1 busy low at done ", tag}, busy, 0);
      check({"R6 R7 prescale ", tag}, prescale, p);
      check({"R6 R7 rate_div ", tag}, rate_div, s);
      check({"R8 no_fit ", tag}, no_fit, e);
      @(negedge clk);
      check({"R1 done single ", tag}, done, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check("watchdog expired", 0, 1);
    report();
  end

  initial begin
    int p, s; bit e, ok;
    logic [7:0] hp, hd;
    void'($urandom(32'd20240611));
    #1;
    check("R9 busy at reset", busy, 0);
    check("R9 done at reset", done, 0);
    check("R9 prescale at reset", prescale, 0);
    check("R9 rate_div at reset", rate_div, 0);
    check("R9 no_fit at reset", no_fit, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    run(32'd0, 32'd0, "zero clock R5");
    run(32'd1, 32'd0, "unit clock R4");
    run(32'd100_000_000, 32'd0, "R5 floor to last pair");
    run(32'd100_000_000, 32'hFFFF_FFFF, "R4 cap to half");
    run(32'd100_000_000, 32'd50_000_000, "R4 exact half");
    run(32'd7_372_800, 32'd1_000_000, "mid rate R7");
    run(32'd1_000_000, 32'd3_333, "truncation edge R7");
    run(32'hFFFF_FFFF, 32'd1, "max clock R5");
    run(32'd65024, 32'd0, "R5 clock equals span");
    run(32'd12_000_000, 32'd46_875, "exact quotient R7");

    // R2: second start while busy is ignored
    ref_search(64'd48_000_000, 64'd400_000, p, s, e);
    @(negedge clk);
    src_hz = 32'd48_000_000; want_hz = 32'd400_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    src_hz = 32'd3_000_000; want_hz = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R2 prescale keeps first request", prescale, p);
    check("R2 rate_div keeps first request", rate_div, s);

    // R3: outputs hold while idle with inputs moving
    hp = prescale; hd = rate_div;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      src_hz = $urandom; want_hz = $urandom;
    end
    check("R3 prescale held idle", prescale, hp);
    check("R3 rate_div held idle", rate_div, hd);
    // and through a search until its done
    @(negedge clk);
    src_hz = 32'd33_000_000; want_hz = 32'd10_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 prescale held while busy", prescale, hp);
    check("R3 rate_div held while busy", rate_div, hd);
    wait_done(ok);

    // random vectors
    for (int k = 0; k < 120; k++) begin
      logic [31:0] c, r;
      c = $urandom;
      case (k % 4)
        0: r = $urandom;
        1: r = $urandom % 32'd2_000_000;
        2: r = c >> ($urandom % 20);
        default: r = $urandom % 32'd5_000;
      endcase
      if (k % 5 == 0) c = c % 32'd200_000;
      run(c, r, "random R7");
    end

    report();
  end
endmodule